// File: doc/BRIEF.md
# Clocked Serial Transfer Sequencer

This block moves one byte at a time over a synchronous serial link made of a shift clock, a data-out line and a data-in line. It can generate the shift clock itself from the system clock, or it can follow a clock that a partner device drives. A four-state controller sequences each transfer. The controller's states are idle, armed, shifting and clock-only. A host strobes commands into the block and loads the outgoing byte in parallel. When a transfer completes or is cut short, an interrupt request flag is raised. The host clears that flag with its own strobe.

Bits travel least significant first. The block updates its output bit on a falling shift-clock edge and samples its input bit on a rising edge; the line idles high. With the internal clock, the block emits exactly eight clock pulses per byte and then stops. With the external clock, the incoming clock first passes through a two-stage synchroniser and then through edge detection. A clock-only state lets the block emit a free-running shift clock without moving any data. A write to the mode register always returns the controller to idle and aborts any transfer in progress.

Top module: `serial_xfer_seq`

## Requirements
- R1: After reset the state output `seqState` is 0 (idle), `sckOut` is 1, `sdo` is 1, `irqFlag` is 0 and `rxData` is 0. The state codes are 0 idle, 1 armed, 2 shifting and 3 clock-only.
- R2: A `startCmd` strobe in idle moves `seqState` to 1 (armed) on the next clock edge.
- R3: With `extClkSel`=1, a synchronised falling edge on `sckIn` in armed enters shifting (2). After eight rising edges of `sckIn`, the state returns to armed (1) and `rxData` holds the eight sampled bits.
- R4: With `extClkSel`=0 and `portMode`≠0, a `clkEnable` strobe in armed enters shifting. `sckOut` then has a period of 4 system clocks and goes low exactly eight times, after which the state is idle (0) and `sckOut` stays high.
- R5: `sdo` presents the loaded byte least significant bit first and changes only on a falling shift-clock edge. `sdi` is sampled on each rising edge, and the first bit sampled lands in `rxData[0]`.
- R6: A `modeWr` strobe in any state returns `seqState` to 0. If that write happens while shifting, `irqFlag` is set.
- R7: A `startCmd` strobe while shifting moves the state to armed and sets `irqFlag`. The bit counter is also cleared, so the next transfer again takes a full eight bits.
- R8: `irqFlag` is set whenever the state leaves shifting and stays set until an `irqClr` strobe. A set and a clear in the same cycle leave the flag set.
- R9: With `extClkSel`=0 and `portMode`=0, a `clkEnable` strobe in armed enters clock-only (3). In that state `sckOut` toggles every 2 system clocks, `sdo` holds its value, and `irqFlag` is not raised. A `modeWr` strobe returns the state to idle with `sckOut` high.
- R10: A `loadWr` strobe replaces the shift register with `loadData` only in idle or armed. During shifting it is ignored, and the bits already loaded continue to be sent.
- R11: `rxData` changes only when a transfer completes all eight bits. An aborted transfer leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWr | input | 1 | Mode-register write strobe; re-initialises the controller |
| startCmd | input | 1 | Start-transfer command strobe |
| extClkSel | input | 1 | 1: follow `sckIn`; 0: generate `sckOut` |
| portMode | input | 2 | Port mode field; 0 selects clock-only entry |
| clkEnable | input | 1 | Enable the internal shift clock from armed |
| loadWr | input | 1 | Parallel load strobe for the outgoing byte |
| loadData | input | 8 | Outgoing byte |
| irqClr | input | 1 | Clear strobe for the interrupt request flag |
| sckIn | input | 1 | External shift clock (asynchronous) |
| sdi | input | 1 | Serial data in |
| sckOut | output | 1 | Generated shift clock, idle high |
| sdo | output | 1 | Serial data out |
| rxData | output | 8 | Last completed received byte |
| irqFlag | output | 1 | Interrupt request flag |
| seqState | output | 2 | Controller state (0 idle, 1 armed, 2 shifting, 3 clock-only) |

## Verification
The embedded properties assume that `extClkSel` changes only while the controller is idle or armed. They also assume that each phase of `sckIn` lasts at least three system clocks, so that the synchroniser sees every edge. The bench switches clock source only between transfers, holds each external clock phase for four cycles, and changes `sdi` only while the shift clock is low. It draws the byte values, port mode and clock source at random. The aborts, the same-cycle set and clear of the flag, the ignored mid-transfer load and clock-only mode are driven as directed cases.

// File: rtl/sxs_pkg.sv
package sxs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SHIFT = 2'd2,
    ST_CONT  = 2'd3
  } seqState_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic driveOut;  // falling shift-clock edge: update sdo
    logic sampleIn;  // rising shift-clock edge: shift sdi in
    logic finish;    // last bit sampled: capture received byte
    logic setIrq;    // controller leaves the shifting state
    logic loadOk;    // parallel load permitted
  } dpStrobe_t;

endpackage

// File: rtl/sxs_ctrl.sv
module sxs_ctrl
  import sxs_pkg::*;
#(
  parameter int BITS = 8,
  parameter int DIV  = 4,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWr,
  input  logic       startCmd,
  input  logic       extClkSel,
  input  logic [1:0] portMode,
  input  logic       clkEnable,
  input  logic       sckIn,
  output logic       sckOut,
  output seqState_t  st,
  output dpStrobe_t  strobe
);

  localparam int CW = $clog2(BITS);
  localparam int DW = $clog2(DIV);
  localparam logic [CW-1:0] LAST_BIT = CW'(BITS - 1);
  localparam logic [DW-1:0] HALF_C   = DW'(DIV / 2);
  localparam logic [DW-1:0] WRAP_C   = DW'(DIV - 1);

  seqState_t       stNext;
  logic [SYNC-1:0] syncQ;
  logic            sckPrev;
  logic [CW-1:0]   bitCnt;
  logic [DW-1:0]   divCnt;
  logic            sckQ;
  logic extFall, extRise, intFall, intRise, pulseFall, pulseRise;
  logic run, runNext, setIrq, doneRx;

  // external clock: synchroniser chain then edge detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '1;
      sckPrev <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC-2:0], sckIn};
      sckPrev <= syncQ[SYNC-1];
    end
  end
  assign extFall = sckPrev & ~syncQ[SYNC-1];
  assign extRise = ~sckPrev & syncQ[SYNC-1];

  // internal clock generator
  assign run     = !extClkSel && (st == ST_SHIFT || st == ST_CONT);
  assign runNext = !extClkSel && (stNext == ST_SHIFT || stNext == ST_CONT);
  assign intFall = run && (divCnt == '0);
  assign intRise = run && (divCnt == HALF_C);

  assign pulseFall = extClkSel ? extFall : intFall;
  assign pulseRise = extClkSel ? extRise : intRise;

  always_comb begin
    stNext = st;
    setIrq = 1'b0;
    doneRx = 1'b0;
    if (modeWr) begin
      stNext = ST_IDLE;
      setIrq = (st == ST_SHIFT);
    end else begin
      unique case (st)
        ST_IDLE:  if (startCmd) stNext = ST_ARMED;
        ST_ARMED: begin
          if (extClkSel) begin
            if (extFall) stNext = ST_SHIFT;
          end else if (clkEnable) begin
            stNext = (portMode == 2'b00) ? ST_CONT : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (startCmd) begin
            stNext = ST_ARMED;
            setIrq = 1'b1;
          end else if (pulseRise && bitCnt == LAST_BIT) begin
            stNext = extClkSel ? ST_ARMED : ST_IDLE;
            setIrq = 1'b1;
            doneRx = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.driveOut = !modeWr &&
                      ((st == ST_SHIFT && !startCmd && pulseFall) ||
                       (st == ST_ARMED && extClkSel && extFall));
    strobe.sampleIn = !modeWr && !startCmd && st == ST_SHIFT && pulseRise;
    strobe.finish   = doneRx;
    strobe.setIrq   = setIrq;
    strobe.loadOk   = (st == ST_IDLE) || (st == ST_ARMED);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      bitCnt <= '0;
      divCnt <= '0;
      sckQ   <= 1'b1;
    end else begin
      st <= stNext;
      if (st != ST_SHIFT || stNext != ST_SHIFT) bitCnt <= '0;
      else if (strobe.sampleIn)                bitCnt <= bitCnt + 1'b1;
      if (!run || !runNext)      divCnt <= '0;
      else if (divCnt == WRAP_C) divCnt <= '0;
      else                       divCnt <= divCnt + 1'b1;
      if (!runNext)     sckQ <= 1'b1;
      else if (intFall) sckQ <= 1'b0;
      else if (intRise) sckQ <= 1'b1;
    end
  end

  assign sckOut = sckQ;

  // idle: generated clock parked high, counter at zero
  assert_idle_parked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE) |-> (sckOut && bitCnt == '0));

  // clock-only state never moves data
  assert_cont_no_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CONT) |-> (!strobe.driveOut && !strobe.sampleIn && !strobe.setIrq));

  // counter advances only on a sampled bit while shifting
  assert_count_steps_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(st) == ST_SHIFT && st == ST_SHIFT && !$past(strobe.sampleIn))
      |-> $stable(bitCnt));

endmodule

// File: rtl/sxs_dpath.sv
module sxs_dpath
  import sxs_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic            loadWr,
  input  logic [BITS-1:0] loadData,
  input  logic            sdi,
  input  logic            irqClr,
  output logic            sdo,
  output logic [BITS-1:0] rxData,
  output logic            irqFlag
);

  logic [BITS-1:0] shiftQ;
  logic [BITS-1:0] rxQ;
  logic            sdoQ;
  logic            irqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxQ    <= '0;
      sdoQ   <= 1'b1;
      irqQ   <= 1'b0;
    end else begin
      if (strobe.sampleIn)              shiftQ <= {sdi, shiftQ[BITS-1:1]};
      else if (loadWr && strobe.loadOk) shiftQ <= loadData;
      if (strobe.driveOut) sdoQ <= shiftQ[0];
      if (strobe.finish)   rxQ  <= {sdi, shiftQ[BITS-1:1]};
      if (strobe.setIrq)   irqQ <= 1'b1;
      else if (irqClr)     irqQ <= 1'b0;
    end
  end

  assign sdo     = sdoQ;
  assign rxData  = rxQ;
  assign irqFlag = irqQ;

  assert_irq_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setIrq |=> irqFlag);

  assert_load_refused_R10: assert property (@(posedge clk) disable iff (!rstN)
    (loadWr && !strobe.loadOk && !strobe.sampleIn) |=> $stable(shiftQ));

  assert_rx_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(rxData));

endmodule

// File: rtl/serial_xfer_seq.sv
module serial_xfer_seq
  import sxs_pkg::*;
#(
  parameter int BITS = 8,
  parameter int DIV  = 4,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeWr,
  input  logic            startCmd,
  input  logic            extClkSel,
  input  logic [1:0]      portMode,
  input  logic            clkEnable,
  input  logic            loadWr,
  input  logic [BITS-1:0] loadData,
  input  logic            irqClr,
  input  logic            sckIn,
  input  logic            sdi,
  output logic            sckOut,
  output logic            sdo,
  output logic [BITS-1:0] rxData,
  output logic            irqFlag,
  output logic [1:0]      seqState
);

  seqState_t  st;
  dpStrobe_t  strobe;

  sxs_ctrl #(.BITS(BITS), .DIV(DIV), .SYNC(SYNC)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .startCmd(startCmd),
    .extClkSel(extClkSel), .portMode(portMode), .clkEnable(clkEnable),
    .sckIn(sckIn), .sckOut(sckOut), .st(st), .strobe(strobe)
  );

  sxs_dpath #(.BITS(BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadWr(loadWr),
    .loadData(loadData), .sdi(sdi), .irqClr(irqClr), .sdo(sdo),
    .rxData(rxData), .irqFlag(irqFlag)
  );

  assign seqState = st;

  // any exit from shifting leaves the flag raised
  assert_exit_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(st) == ST_SHIFT && st != ST_SHIFT) |-> irqFlag);

  assert_cont_sdo_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(st) == ST_CONT && st == ST_CONT) |-> $stable(sdo));

  assert_mode_write_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    modeWr |=> (st == ST_IDLE));

endmodule

// File: tb/serial_xfer_seq_bench.sv
`timescale 1ns/1ps
module serial_xfer_seq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeWr = 0, startCmd = 0, extClkSel = 0, clkEnable = 0;
  logic [1:0] portMode = 2'b01;
  logic       loadWr = 0, irqClr = 0, sckIn = 1, sdi = 0;
  logic [7:0] loadData = 0;
  logic       sckOut, sdo, irqFlag;
  logic [7:0] rxData;
  logic [1:0] seqState;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_xfer_seq u_serial_xfer_seq (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .startCmd(startCmd),
    .extClkSel(extClkSel), .portMode(portMode), .clkEnable(clkEnable),
    .loadWr(loadWr), .loadData(loadData), .irqClr(irqClr), .sckIn(sckIn),
    .sdi(sdi), .sckOut(sckOut), .sdo(sdo), .rxData(rxData),
    .irqFlag(irqFlag), .seqState(seqState)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // state after a full transfer: armed for external clock, idle for internal
  function automatic logic [1:0] stateAfter(input bit ext);
    return ext ? 2'd1 : 2'd0;
  endfunction

  task automatic loadByte(input logic [7:0] b);
    loadData = b; loadWr = 1; tick(1); loadWr = 0;
  endtask

  task automatic pulseStart();
    startCmd = 1; tick(1); startCmd = 0;
  endtask

  task automatic clearIrq();
    irqClr = 1; tick(1); irqClr = 0;
    chk(irqFlag == 1'b0, "R8 clear", irqFlag, 0);
  endtask

  // drive nPulses external clock pulses; check bits when complete
  task automatic extXfer(input logic [7:0] tx, input logic [7:0] rx, input int nPulses);
    logic [7:0] got = 0;
    for (int i = 0; i < nPulses; i++) begin
      sckIn = 0; sdi = rx[i];
      tick(4);
      got[i] = sdo;
      sckIn = 1;
      tick(4);
    end
    if (nPulses == 8) begin
      chk(got == tx, "R5 ext sdo order", got, tx);
      chk(rxData == rx, "R3 ext rxData", rxData, rx);
      chk(seqState == stateAfter(1), "R3 ext back to armed", seqState, 1);
      chk(irqFlag == 1'b1, "R8 ext irq", irqFlag, 1);
    end
  endtask

  // start an internal transfer from armed and follow sckOut
  task automatic intXfer(input logic [7:0] tx, input logic [7:0] rx, input bit midLoad);
    logic [7:0] got = 0;
    int falls = 0, firstFall = -1, secondFall = -1, badSdo = 0;
    logic prevSck = 1, prevSdo;
    clkEnable = 1; tick(1); clkEnable = 0;
    prevSdo = sdo;
    for (int c = 0; c < 50; c++) begin
      tick(1);
      if (midLoad && c == 10) begin loadData = ~tx; loadWr = 1; end
      else loadWr = 0;
      if (prevSck && !sckOut) begin
        if (falls < 8) begin got[falls] = sdo; sdi = rx[falls]; end
        if (falls == 0) firstFall = c;
        if (falls == 1) secondFall = c;
        falls++;
      end else if (sdo != prevSdo) badSdo++;
      prevSck = sckOut; prevSdo = sdo;
    end
    loadWr = 0;
    chk(falls == 8, "R4 eight pulses", falls, 8);
    chk(secondFall - firstFall == 4, "R4 period", secondFall - firstFall, 4);
    chk(badSdo == 0, "R5 sdo only on fall", badSdo, 0);
    chk(got == tx, midLoad ? "R10 load ignored" : "R5 int sdo order", got, tx);
    chk(rxData == rx, "R11 int rxData", rxData, rx);
    chk(seqState == stateAfter(0) && sckOut, "R4 idle after", {seqState, sckOut}, 3'b001);
    chk(irqFlag == 1'b1, "R8 int irq", irqFlag, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c1d));
    tick(3); rstN = 1; tick(1);
    chk(seqState == 2'd0, "R1 state", seqState, 0);
    chk(sckOut == 1'b1 && sdo == 1'b1, "R1 lines", {sckOut, sdo}, 2'b11);
    chk(irqFlag == 1'b0, "R1 irq", irqFlag, 0);
    chk(rxData == 8'h00, "R1 rxData", rxData, 0);

    pulseStart();
    chk(seqState == 2'd1, "R2 start to armed", seqState, 1);

    // random transfers
    for (int i = 0; i < 16; i++) begin
      logic [7:0] tx, rx;
      bit ext;
      ext = $urandom % 2;
      tx = 8'($urandom); rx = 8'($urandom);
      extClkSel = ext; portMode = 2'(1 + ($urandom % 3));
      loadByte(tx);
      if (seqState == 2'd0) pulseStart();
      if (ext) extXfer(tx, rx, 8); else intXfer(tx, rx, 0);
      clearIrq();
    end

    // load while shifting is refused
    extClkSel = 0; portMode = 2'b10;
    if (seqState == 2'd0) pulseStart();
    loadByte(8'h3c);
    intXfer(8'h3c, 8'hc3, 1);
    clearIrq();

    // mode write aborts, with a same-cycle clear
    pulseStart();
    loadByte(8'h5a);
    clkEnable = 1; tick(1); clkEnable = 0;
    tick(10);
    chk(seqState == 2'd2, "R4 shifting", seqState, 2);
    modeWr = 1; irqClr = 1; tick(1); modeWr = 0; irqClr = 0;
    chk(seqState == 2'd0, "R6 abort to idle", seqState, 0);
    chk(irqFlag == 1'b1, "R8 set beats clear", irqFlag, 1);
    chk(rxData == 8'hc3, "R11 abort keeps rx", rxData, 8'hc3);
    clearIrq();

    // start command while shifting, then a full transfer
    extClkSel = 1;
    pulseStart();
    loadByte(8'h96);
    extXfer(8'h96, 8'h11, 3);
    chk(seqState == 2'd2, "R3 ext shifting", seqState, 2);
    pulseStart();
    chk(seqState == 2'd1, "R7 back to armed", seqState, 1);
    chk(irqFlag == 1'b1, "R7 irq", irqFlag, 1);
    chk(rxData == 8'hc3, "R11 rx kept", rxData, 8'hc3);
    clearIrq();
    loadByte(8'he1);
    extXfer(8'he1, 8'h7e, 8);
    clearIrq();

    // clock-only mode
    extClkSel = 0; portMode = 2'b00;
    begin
      int toggles = 0;
      logic prevSck, sdo0;
      clkEnable = 1; tick(1); clkEnable = 0;
      chk(seqState == 2'd3, "R9 enter clock-only", seqState, 3);
      prevSck = sckOut; sdo0 = sdo;
      for (int c = 0; c < 16; c++) begin
        tick(1);
        if (sckOut != prevSck) toggles++;
        prevSck = sckOut;
        if (sdo != sdo0) toggles += 100;
      end
      chk(toggles == 8, "R9 toggles, sdo held", toggles, 8);
      chk(irqFlag == 1'b0, "R9 no irq", irqFlag, 0);
      modeWr = 1; tick(1); modeWr = 0;
      chk(seqState == 2'd0, "R9 mode write exits", seqState, 0);
      tick(1);
      chk(sckOut == 1'b1, "R9 clock parked", sckOut, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule